// File: doc/BRIEF.md
# Variable-Length Program Counter

This block keeps the word address of the instruction being fetched for a processor whose instructions occupy one or two 16-bit words. Every cycle it receives the word at the current address and the word that follows it. It classifies the first word as a one-word instruction, a two-word data-access instruction, or a two-word absolute jump. It then steps forward by one or two words, or loads the jump target. A stall input freezes it.

The address is 14 bits wide and counts whole instruction words. Program memory is paged, with 256 pages of 64 words each, so the block also presents the current address as an 8-bit page index and a 6-bit slot within that page. The reset input is asynchronous and active low. Its release is synchronised inside the block, and after reset the counter starts at word 0, which is the reset vector.

Top module: `pc_counter`

## Requirements
- R1: While reset is asserted, and after it is released until the first enabled update, the address, page and offset outputs are all 0.
- R2: On a clock edge with stall low, any opcode that is not one of the three two-word forms below advances the address by 1.
- R3: On a clock edge with stall low, an opcode matching 1001 000x xxxx 0000 (load-direct; the x bits are ignored) advances the address by 2.
- R4: On a clock edge with stall low, an opcode matching 1001 001x xxxx 0000 (store-direct) advances the address by 2.
- R5: On a clock edge with stall low, an opcode matching 1001 010x xxxx 110x (absolute jump) loads the address with bits 13:0 of the operand word, and operand bits 15:14 have no effect.
- R6: Address arithmetic wraps modulo 2^14: 0x3FFF+1 gives 0x0000, 0x3FFE+2 gives 0x0000, and 0x3FFF+2 gives 0x0001.
- R7: On a clock edge with stall high, the address keeps its value whatever the opcode, including a jump.
- R8: The page output equals address bits 13:6 and the offset output equals address bits 5:0.
- R9: An opcode that differs from a two-word form only in its low nibble (for example 0x9001, 0x9208 or 0x9408) is treated as one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised internally |
| stall | input | 1 | High holds the address unchanged |
| op_word | input | 16 | Instruction word fetched at the current address |
| operand_word | input | 16 | Word following the current address (second word of a two-word instruction) |
| pc_word | output | 14 | Current instruction word address |
| pc_page | output | 8 | Page index of the current address |
| pc_offset | output | 6 | Word slot within the page |

## Verification
The address register updates at the rising edge that samples a given opcode and operand. The page and offset fields follow in the same cycle through combinational logic only. The bench therefore drives each input set at a falling edge, lets one rising edge pass, and compares all three outputs 2 ns later against a model stepped once for that edge. Reset release takes two extra edges in the synchroniser, so the bench keeps stall high for four edges after each release. During that window it expects the address to stay at 0.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int unsigned INSN_W = 16;

  typedef enum logic [1:0] {
    KIND_ONE  = 2'd0,
    KIND_DATA = 2'd1,
    KIND_JUMP = 2'd2
  } insn_kind_e;

  localparam logic [INSN_W-1:0] DATA_MASK = 16'hFE0F;
  localparam logic [INSN_W-1:0] LOAD_PAT  = 16'h9000;
  localparam logic [INSN_W-1:0] STORE_PAT = 16'h9200;
  localparam logic [INSN_W-1:0] JUMP_MASK = 16'hFE0E;
  localparam logic [INSN_W-1:0] JUMP_PAT  = 16'h940C;
endpackage

// File: rtl/pc_len_decode.sv
module pc_len_decode
  import pc_pkg::*;
(
  input  logic [INSN_W-1:0] op_word,
  output insn_kind_e        kind
);
  logic is_load;
  logic is_store;
  logic is_jump;

  always_comb begin
    is_load  = (op_word & DATA_MASK) == LOAD_PAT;
    is_store = (op_word & DATA_MASK) == STORE_PAT;
    is_jump  = (op_word & JUMP_MASK) == JUMP_PAT;
    if (is_jump)                 kind = KIND_JUMP;
    else if (is_load || is_store) kind = KIND_DATA;
    else                         kind = KIND_ONE;
  end
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_pkg::*;
#(
  parameter int unsigned ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  insn_kind_e        kind,
  input  logic [INSN_W-1:0] operand_word,
  output logic [ADDR_W-1:0] pc_nxt
);
  localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

  always_comb begin
    unique case (kind)
      KIND_JUMP: pc_nxt = operand_word[ADDR_W-1:0];
      KIND_DATA: pc_nxt = pc_cur + STEP_TWO;
      default:   pc_nxt = pc_cur + STEP_ONE;
    endcase
  end
endmodule

// File: rtl/pc_addr_split.sv
module pc_addr_split #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned OFFS_W = 6,
  localparam int unsigned PAGE_W = ADDR_W - OFFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [PAGE_W-1:0] page,
  output logic [OFFS_W-1:0] offset
);
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b < OFFS_W) begin : g_off
      assign offset[b] = addr[b];
    end else begin : g_page
      assign page[b-OFFS_W] = addr[b];
    end
  end
endmodule

// File: rtl/pc_counter.sv
module pc_counter
  import pc_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned OFFS_W = 6,
  localparam int unsigned PAGE_W = ADDR_W - OFFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic [INSN_W-1:0] op_word,
  input  logic [INSN_W-1:0] operand_word,
  output logic [ADDR_W-1:0] pc_word,
  output logic [PAGE_W-1:0] pc_page,
  output logic [OFFS_W-1:0] pc_offset
);
  logic [1:0]        rst_sync;
  logic              rst_q;
  insn_kind_e        kind;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_d;
  logic              pc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  pc_len_decode u_dec (
    .op_word (op_word),
    .kind    (kind)
  );

  pc_next_calc #(.ADDR_W(ADDR_W)) u_next (
    .pc_cur       (pc_q),
    .kind         (kind),
    .operand_word (operand_word),
    .pc_nxt       (pc_d)
  );

  assign pc_en = ~stall;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_word = pc_q;

  pc_addr_split #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_split (
    .addr   (pc_q),
    .page   (pc_page),
    .offset (pc_offset)
  );
endmodule

// File: rtl/pc_counter_chk.sv
module pc_counter_chk #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned OFFS_W = 6
) (
  input logic                     clk,
  input logic                     rst_q,
  input logic                     stall,
  input logic [15:0]              op_word,
  input logic [15:0]              operand_word,
  input logic [ADDR_W-1:0]        pc_word,
  input logic [ADDR_W-OFFS_W-1:0] pc_page,
  input logic [OFFS_W-1:0]        pc_offset
);
  logic c_load, c_store, c_jump;
  assign c_load  = (op_word[15:9] == 7'b1001000) && (op_word[3:0] == 4'b0000);
  assign c_store = (op_word[15:9] == 7'b1001001) && (op_word[3:0] == 4'b0000);
  assign c_jump  = (op_word[15:9] == 7'b1001010) && (op_word[3:1] == 3'b110);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    stall |=> $stable(pc_word));

  // R2
  one_word_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!stall && !c_load && !c_store && !c_jump) |=> pc_word == ADDR_W'($past(pc_word) + 1));

  // R3
  load_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!stall && c_load) |=> pc_word == ADDR_W'($past(pc_word) + 2));

  // R4
  store_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!stall && c_store) |=> pc_word == ADDR_W'($past(pc_word) + 2));

  // R5
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!stall && c_jump) |=> pc_word == $past(operand_word[ADDR_W-1:0]));

  // R8
  split_fields_chk: assert property (@(posedge clk) disable iff (!rst_q)
    {pc_page, pc_offset} == pc_word);
endmodule

bind pc_counter pc_counter_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_chk (
  .clk          (clk),
  .rst_q        (rst_q),
  .stall        (stall),
  .op_word      (op_word),
  .operand_word (operand_word),
  .pc_word      (pc_word),
  .pc_page      (pc_page),
  .pc_offset    (pc_offset)
);

// File: tb/pc_counter_test.sv
module pc_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [15:0] op_word;
  logic [15:0] operand_word;
  logic [13:0] pc_word;
  logic [7:0]  pc_page;
  logic [5:0]  pc_offset;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_pc;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pc_counter uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall        (stall),
    .op_word      (op_word),
    .operand_word (operand_word),
    .pc_word      (pc_word),
    .pc_page      (pc_page),
    .pc_offset    (pc_offset)
  );

  function automatic logic [13:0] model_next(logic [13:0] pc, logic [15:0] op,
                                             logic [15:0] opd, logic st);
    if (st) return pc;
    if ((op & 16'hFE0E) == 16'h940C) return opd[13:0];
    if ((op & 16'hFE0F) == 16'h9000 || (op & 16'hFE0F) == 16'h9200) return pc + 14'd2;
    return pc + 14'd1;
  endfunction

  function automatic string tag_of(logic [15:0] op, logic st);
    if (st) return "R7";
    if ((op & 16'hFE0E) == 16'h940C) return "R5";
    if ((op & 16'hFE0F) == 16'h9000) return "R3";
    if ((op & 16'hFE0F) == 16'h9200) return "R4";
    return "R2";
  endfunction

  task automatic check_all(string req);
    checks++;
    if (pc_word !== exp_pc) begin
      errors++;
      $display("FAIL %s pc_word actual %h expected %h", req, pc_word, exp_pc);
    end
    checks++;
    if (pc_page !== exp_pc[13:6] || pc_offset !== exp_pc[5:0]) begin
      errors++;
      $display("FAIL R8 (%s) page/offset actual %h/%h expected %h/%h",
               req, pc_page, pc_offset, exp_pc[13:6], exp_pc[5:0]);
    end
  endtask

  task automatic step(logic [15:0] op, logic [15:0] opd, logic st, string req);
    @(negedge clk);
    op_word = op; operand_word = opd; stall = st;
    @(posedge clk);
    exp_pc = model_next(exp_pc, op, opd, st);
    #2;
    check_all(req);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    stall = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    check_all("R1");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; stall = 1'b1; op_word = 16'h0000; operand_word = 16'h0000;
    exp_pc = 14'd0;
    repeat (3) @(posedge clk);
    #2;
    check_all("R1");
    release_reset();

    // directed: one-word and two-word steps
    step(16'h0C01, 16'h0000, 1'b0, "R2");   // 0 -> 1
    step(16'h91F0, 16'hFFFF, 1'b0, "R3");   // 1 -> 3
    step(16'h93F0, 16'h1234, 1'b0, "R4");   // 3 -> 5
    // near misses in the low nibble are one word
    step(16'h9001, 16'h0000, 1'b0, "R9");
    step(16'h9208, 16'h0000, 1'b0, "R9");
    step(16'h9408, 16'h0000, 1'b0, "R9");
    // jump with high operand bits set and both k bit variants
    step(16'h95FD, 16'hC123, 1'b0, "R5");
    step(16'h940C, 16'h8000, 1'b0, "R5");
    // stall holds even on a jump
    step(16'h940C, 16'h1111, 1'b1, "R7");
    step(16'h9000, 16'h0000, 1'b1, "R7");
    // wrap cases
    step(16'h940C, 16'h3FFF, 1'b0, "R5");
    step(16'h0000, 16'h0000, 1'b0, "R6");   // 3FFF -> 0000
    step(16'h940C, 16'h3FFE, 1'b0, "R5");
    step(16'h9000, 16'h0000, 1'b0, "R6");   // 3FFE -> 0000
    step(16'h940C, 16'h3FFF, 1'b0, "R5");
    step(16'h9200, 16'h0000, 1'b0, "R6");   // 3FFF -> 0001
    // page boundary
    step(16'h940C, 16'h007F, 1'b0, "R5");
    step(16'h0000, 16'h0000, 1'b0, "R8");

    // asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    exp_pc = 14'd0;
    check_all("R1");
    release_reset();

    for (int i = 0; i < 600; i++) begin
      logic [15:0] op;
      logic [15:0] opd;
      logic st;
      int sel;
      sel = int'($urandom % 8);
      opd = 16'($urandom);
      st  = ($urandom % 8) == 0;
      case (sel)
        0: op = 16'h9000 | (16'($urandom) & 16'h01F0);
        1: op = 16'h9200 | (16'($urandom) & 16'h01F0);
        2: op = 16'h940C | (16'($urandom) & 16'h01F1);
        3: op = 16'h9000 | (16'($urandom) & 16'h07F0) | 16'(1 + $urandom % 15);
        default: op = 16'($urandom);
      endcase
      step(op, opd, st, tag_of(op, st));
    end

    finish_run();
  end
endmodule